// File: doc/BRIEF.md
# Priority-Aged Instruction Dispatch Switch

This block sits between a set of master processors and a bank of shared co-processor units. Every master may present one instruction packet per cycle, along with the number of the task that issued it and a single bit that marks that task as urgent or ordinary. The upper four bits of the instruction name a co-processor type. Type zero stays with the master and is never forwarded. Types one to fifteen each have their own output lane.

When several masters aim at the same type in one cycle, that type's arbiter picks one winner. An urgent request beats an ordinary one. Inside a class, the request that has waited longest wins, and on a full tie the lowest master index wins. Each master has a saturating wait counter that makes a starved request older every cycle, so every request is served in the end. The winning packet is registered onto its lane together with the master index and task number, and the winning master gets a one-cycle accept pulse. A master that loses simply keeps its request up.

Top module: `instr_dispatch_xbar`

## Requirements
- R1: The type of a packet is bits [INSTR_W-1 -: 4] of its instruction. A granted packet of type t (1..15) appears on lane t-1 with `cop_valid` high, the full instruction, the master index and the task number.
- R2: A request whose type is 0 is never forwarded and never accepted, however long it stays up.
- R3: The lanes are arbitrated independently, so requests for different types that arrive in the same cycle are all granted in that cycle. The number of accept pulses equals the number of valid lanes.
- R4: A request with `req_high`=1 wins over any request with `req_high`=0 for the same type, whatever its age.
- R5: Inside one class the request with the larger wait count wins. A master's wait count goes up by one for each cycle its request is pending and not granted, saturates at 2**AGE_W-1, and returns to 0 on a grant or when no request is pending.
- R6: When class and wait count are equal, the lowest master index wins.
- R7: `req_accept[m]` is a one-cycle pulse in the same cycle as the lane output. A request presented while its own accept is high is not considered, so the master can retire it or replace it at the next edge.
- R8: A request with no contention, presented in cycle c, is on its lane in cycle c+1.
- R9: While reset is high and in the first cycle after it, every `cop_valid` and `req_accept` bit is 0.
- R10: A losing master's request is not lost. It is granted later, as long as it stays up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | N_MASTERS | Request present, one bit per master |
| req_instr | input | N_MASTERS*INSTR_W | Instruction of each master, master m at slice m |
| req_high | input | N_MASTERS | 1 = urgent priority class |
| req_task | input | N_MASTERS*TASK_W | Issuing task number per master |
| req_accept | output | N_MASTERS | One-cycle accept pulse per master |
| cop_valid | output | 15 | Lane k holds a packet of type k+1 |
| cop_instr | output | 15*INSTR_W | Forwarded instruction per lane |
| cop_master | output | 15*IDX_W | Index of the master that issued it |
| cop_task | output | 15*TASK_W | Task number of the issuer |

## Verification
Grants on different lanes can fall in the same cycle, and so can the accept pulses that go with them. The bench provokes this by raising three requests for three distinct types at one falling edge. It expects all three lanes valid at the next sample, each with its own master, and each of the three masters' accept bits high at the same time. Queued expectations are listed in lane order. A grant that slips into the next cycle, or a missing accept, shows up as a mismatch in the scoreboard.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dispatch_age_tracker.sv
module dispatch_age_tracker #(
  parameter int AGE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic             granted,
  output logic [AGE_W-1:0] age
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                    age <= '0;
    else if (!pending || granted) age <= '0;
    else if (age != AGE_MAX)    age <= age + 1'b1;
  end

  AST_AGE_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (pending && !granted && age == AGE_MAX) |=> (age == AGE_MAX)); // R5
endmodule

// File: rtl/dispatch_type_arbiter.sv
module dispatch_type_arbiter #(
  parameter int N     = 4,
  parameter int AGE_W = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     cand,
  input  logic [N-1:0]     high,
  input  logic [N*AGE_W-1:0] age_flat,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] win_idx,
  output logic             any
);
  localparam int KEY_W = AGE_W + 1;
  logic [KEY_W-1:0] best_key;
  logic [KEY_W-1:0] key;

  always_comb begin
    best_key = '0;
    key      = '0;
    any      = 1'b0;
    win_idx  = '0;
    for (int m = 0; m < N; m++) begin
      key = {high[m], age_flat[m*AGE_W +: AGE_W]};
      if (cand[m] && (!any || key > best_key)) begin
        any      = 1'b1;
        best_key = key;
        win_idx  = IDX_W'(m);
      end
    end
    grant = '0;
    if (any) grant[win_idx] = 1'b1;
  end

  AST_GRANT_FROM_CAND: assert property (@(posedge clk) disable iff (rst)
    (grant & ~cand) == '0); // R3
  AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (rst)
    (any && (grant & high) == '0) |-> ((cand & high) == '0)); // R4
endmodule

// File: rtl/instr_dispatch_xbar.sv
module instr_dispatch_xbar #(
  parameter int N_MASTERS = 4,
  parameter int INSTR_W   = 16,
  parameter int TASK_W    = 4,
  parameter int AGE_W     = 4,
  parameter int TYPE_W    = 4,
  parameter int IDX_W     = dispatch_pkg::idx_width(N_MASTERS),
  parameter int N_LANES   = (1 << TYPE_W) - 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_MASTERS-1:0]         req_valid,
  input  logic [N_MASTERS*INSTR_W-1:0] req_instr,
  input  logic [N_MASTERS-1:0]         req_high,
  input  logic [N_MASTERS*TASK_W-1:0]  req_task,
  output logic [N_MASTERS-1:0]         req_accept,
  output logic [N_LANES-1:0]           cop_valid,
  output logic [N_LANES*INSTR_W-1:0]   cop_instr,
  output logic [N_LANES*IDX_W-1:0]     cop_master,
  output logic [N_LANES*TASK_W-1:0]    cop_task
);
  localparam int TYPE_LSB = INSTR_W - TYPE_W;

  logic [INSTR_W-1:0]    instr_a [N_MASTERS];
  logic [TASK_W-1:0]     task_a  [N_MASTERS];
  logic [TYPE_W-1:0]     type_a  [N_MASTERS];
  logic [N_MASTERS-1:0]  pending;
  logic [N_MASTERS-1:0]  master_grant;
  logic [N_MASTERS*AGE_W-1:0] age_flat;
  logic [N_MASTERS-1:0]  lane_grant [N_LANES];

  always_comb begin
    for (int m = 0; m < N_MASTERS; m++) begin
      instr_a[m] = req_instr[m*INSTR_W +: INSTR_W];
      task_a[m]  = req_task[m*TASK_W +: TASK_W];
      type_a[m]  = instr_a[m][TYPE_LSB +: TYPE_W];
      pending[m] = req_valid[m] && (type_a[m] != '0) && !req_accept[m];
    end
  end

  always_comb begin
    master_grant = '0;
    for (int k = 0; k < N_LANES; k++) master_grant = master_grant | lane_grant[k];
  end

  always_ff @(posedge clk) begin
    if (rst) req_accept <= '0;
    else     req_accept <= master_grant;
  end

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_master
    dispatch_age_tracker #(.AGE_W(AGE_W)) age_i (
      .clk(clk), .rst(rst), .pending(pending[m]), .granted(master_grant[m]),
      .age(age_flat[m*AGE_W +: AGE_W]));

    AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (rst)
      req_accept[m] |=> !req_accept[m]); // R7
    AST_TYPE0_DROPPED: assert property (@(posedge clk) disable iff (rst)
      req_accept[m] |-> ($past(type_a[m]) != '0)); // R2
  end

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    logic [N_MASTERS-1:0] cand;
    logic [IDX_W-1:0]     win_idx;
    logic                 any;

    always_comb begin
      for (int m = 0; m < N_MASTERS; m++)
        cand[m] = pending[m] && (type_a[m] == TYPE_W'(k + 1));
    end

    dispatch_type_arbiter #(.N(N_MASTERS), .AGE_W(AGE_W), .IDX_W(IDX_W)) arb_i (
      .clk(clk), .rst(rst), .cand(cand), .high(req_high), .age_flat(age_flat),
      .grant(lane_grant[k]), .win_idx(win_idx), .any(any));

    always_ff @(posedge clk) begin
      if (rst) begin
        cop_valid[k]                       <= 1'b0;
        cop_instr[k*INSTR_W +: INSTR_W]    <= '0;
        cop_master[k*IDX_W +: IDX_W]       <= '0;
        cop_task[k*TASK_W +: TASK_W]       <= '0;
      end else begin
        cop_valid[k] <= any;
        if (any) begin
          cop_instr[k*INSTR_W +: INSTR_W] <= instr_a[win_idx];
          cop_master[k*IDX_W +: IDX_W]    <= win_idx;
          cop_task[k*TASK_W +: TASK_W]    <= task_a[win_idx];
        end
      end
    end

    AST_ROUTE_TYPE: assert property (@(posedge clk) disable iff (rst)
      cop_valid[k] |-> (cop_instr[k*INSTR_W + TYPE_LSB +: TYPE_W] == TYPE_W'(k + 1))); // R1
  end

  AST_ACCEPT_PAIRED: assert property (@(posedge clk) disable iff (rst)
    $countones(req_accept) == $countones(cop_valid)); // R3
endmodule

// File: tb/instr_dispatch_xbar_tb_top.sv
module instr_dispatch_xbar_tb_top;
  localparam int NM = 4, IW = 16, TW = 4, XW = 2, NL = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NM-1:0]    req_valid = '0;
  logic [NM*IW-1:0] req_instr = '0;
  logic [NM-1:0]    req_high  = '0;
  logic [NM*TW-1:0] req_task  = '0;
  logic [NM-1:0]    req_accept;
  logic [NL-1:0]    cop_valid;
  logic [NL*IW-1:0] cop_instr;
  logic [NL*XW-1:0] cop_master;
  logic [NL*TW-1:0] cop_task;

  instr_dispatch_xbar dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_instr(req_instr),
    .req_high(req_high), .req_task(req_task), .req_accept(req_accept),
    .cop_valid(cop_valid), .cop_instr(cop_instr), .cop_master(cop_master),
    .cop_task(cop_task));

  always #2 clk = ~clk;

  typedef struct {
    int lane; int master; logic [IW-1:0] instr; logic [TW-1:0] tsk; string req;
  } exp_t;
  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(input int m, input logic [3:0] typ, input logic hi,
                       input logic [TW-1:0] tk, input logic [11:0] pl);
    req_instr[m*IW +: IW] = {typ, pl};
    req_task[m*TW +: TW]  = tk;
    req_high[m]           = hi;
    req_valid[m]          = 1'b1;
  endtask

  task automatic expect_item(input int lane, input int m, input logic [IW-1:0] ins,
                             input logic [TW-1:0] tk, input string req);
    exp_t e;
    e.lane = lane; e.master = m; e.instr = ins; e.tsk = tk; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 60) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  // retire: a master drops its request once it sees the accept pulse
  always @(posedge clk) begin
    #1;
    for (int m = 0; m < NM; m++) if (req_accept[m]) req_valid[m] = 1'b0;
  end

  // monitor: compare every lane output with the scoreboard, lane order
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int k = 0; k < NL; k++) begin
        if (cop_valid[k]) begin
          if (exp_q.size() == 0) begin
            check(0, "R2 unexpected lane output", k, -1);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(k == e.lane, {e.req, " lane"}, k, e.lane);
            check(int'(cop_master[k*XW +: XW]) == e.master, {e.req, " master"},
                  int'(cop_master[k*XW +: XW]), e.master);
            check(cop_instr[k*IW +: IW] == e.instr, {e.req, " R1 instr"},
                  int'(cop_instr[k*IW +: IW]), int'(e.instr));
            check(cop_task[k*TW +: TW] == e.tsk, {e.req, " R1 task"},
                  int'(cop_task[k*TW +: TW]), int'(e.tsk));
            check(req_accept[cop_master[k*XW +: XW]] == 1'b1, {e.req, " R7 accept"},
                  int'(req_accept[cop_master[k*XW +: XW]]), 1);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cop_valid == '0, "R9 lanes in reset", int'(cop_valid), 0);
    check(req_accept == '0, "R9 accept in reset", int'(req_accept), 0);
    rst = 1'b0;
    @(negedge clk);
    check(cop_valid == '0, "R9 lanes after reset", int'(cop_valid), 0);
    check(req_accept == '0, "R9 accept after reset", int'(req_accept), 0);

    // R8 R1: single uncontended request, type 3 -> lane 2
    drive(0, 4'd3, 1'b0, 4'd9, 12'h5A1);
    expect_item(2, 0, 16'h35A1, 4'd9, "R8");
    @(negedge clk);
    check(cop_valid[2] == 1'b1, "R8 one-cycle latency", int'(cop_valid[2]), 1);
    drain();

    // R2: type 0 is held but never forwarded or accepted
    drive(1, 4'd0, 1'b1, 4'd2, 12'h777);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(req_accept[1] == 1'b0, "R2 no accept for type 0", int'(req_accept[1]), 0);
      check(cop_valid == '0, "R2 no lane for type 0", int'(cop_valid), 0);
    end
    req_valid[1] = 1'b0;
    repeat (2) @(negedge clk);

    // R3: three types in one cycle, three grants together
    drive(0, 4'd1, 1'b0, 4'd1, 12'h011);
    drive(1, 4'd2, 1'b0, 4'd2, 12'h022);
    drive(2, 4'd5, 1'b1, 4'd3, 12'h055);
    expect_item(0, 0, 16'h1011, 4'd1, "R3");
    expect_item(1, 1, 16'h2022, 4'd2, "R3");
    expect_item(4, 2, 16'h5055, 4'd3, "R3");
    @(negedge clk);
    check(req_accept[2:0] == 3'b111, "R3 accepts together", int'(req_accept), 7);
    drain();

    // R4: urgent master 3 beats ordinary master 0 on type 4
    drive(0, 4'd4, 1'b0, 4'd4, 12'h400);
    drive(3, 4'd4, 1'b1, 4'd5, 12'h433);
    expect_item(3, 3, 16'h4433, 4'd5, "R4");
    expect_item(3, 0, 16'h4400, 4'd4, "R4 R10");
    drain();

    // R6: equal class and age, lower index first
    drive(2, 4'd6, 1'b0, 4'd6, 12'h622);
    drive(1, 4'd6, 1'b0, 4'd7, 12'h611);
    expect_item(5, 1, 16'h6611, 4'd7, "R6");
    expect_item(5, 2, 16'h6622, 4'd6, "R6 R10");
    drain();

    // R5: aged master 2 beats a fresh request from master 0
    drive(0, 4'd7, 1'b0, 4'd8, 12'h700);
    drive(1, 4'd7, 1'b0, 4'd9, 12'h711);
    drive(2, 4'd7, 1'b0, 4'd10, 12'h722);
    expect_item(6, 0, 16'h7700, 4'd8, "R5");
    expect_item(6, 1, 16'h7711, 4'd9, "R5");
    expect_item(6, 2, 16'h7722, 4'd10, "R5 aged wins");
    expect_item(6, 0, 16'h77AA, 4'd11, "R5 fresh later");
    do begin @(posedge clk); #1; end while (!req_accept[0]);
    @(negedge clk);
    drive(0, 4'd7, 1'b0, 4'd11, 12'h7AA);
    drain();

    check(exp_q.size() == 0, "R10 all requests served", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule